// File: doc/BRIEF.md
# Random Word Buffer with Ready Handshake

This block gathers a serial stream of random bits from an upstream entropy source and packs it into a 128-bit buffer. Software reads the buffer as four 32-bit words through a simple register port. A ready status flag rises once a fill has finished. Software then reads the words and writes one to the ready flag. That write clears the flag and starts the next fill.

Fills are paced by two counts in a configuration register. A lower bound, in cycles, keeps the ready flag low until that many cycles have passed since the fill began, even if the bits have already arrived. An upper bound marks the cycle by which a full buffer is expected. If the source has not delivered 128 bits by then, a sticky starvation flag is raised and the fill goes on. A global enable in the control register gates the whole engine. Clearing the enable abandons any partial fill. Two mask bits in the control register route the status flags to an interrupt line.

Top module: `rng_word_buffer`

## Requirements
- R1: After reset, the status (0x10), control (0x14) and configuration (0x18) registers all read as zero and `irq` is low.
- R2: When ready is set, offset 0x00 holds the first 32 bits accepted in the fill, with the earliest bit in bit 31. Offsets 0x04, 0x08 and 0x0C hold the next three groups of 32 bits in the same order.
- R3: A fill accepts exactly 128 bits, one per cycle in which `src_valid` is high. Status bit 0 (ready) is never set while fewer than 128 bits have been accepted.
- R4: Ready does not rise until the number of cycles since the fill began has reached the minimum count held in configuration bits 7:0.
- R5: Control bit 10 is the engine enable. While it is 0, no bits are accepted and ready does not rise. Clearing it discards any partially collected fill, and the next fill starts from an empty buffer.
- R6: While ready is set, the four output words keep their values and any bits offered by the source are discarded.
- R7: Writing 1 to status bit 0 clears ready and starts a new fill. Writing 0 to it leaves it unchanged. Reading the status register changes nothing.
- R8: When the maximum count in configuration bits 31:16 is nonzero and the fill cycle count reaches it with fewer than 128 bits accepted, status bit 1 (starve) sets. It stays set until 1 is written to status bit 1, and the fill continues to completion.
- R9: `irq` is high exactly when (ready and control bit 0) or (starve and control bit 1).
- R10: Control reads back bits 10, 1 and 0 as written. Configuration reads back bits 31:16 and 7:0 as written. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Source bit is valid this cycle |
| src_bit | input | 1 | Random bit from the entropy source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked status interrupt |

## Verification
Two situations are hard to reach from the ports. The first is the case where 128 bits are already in the buffer but the minimum pacing count holds ready back. The bench sets a minimum larger than 128, streams a full word set straight after the acknowledge, and then samples ready on either side of the exact cycle where the count is met. The second is starvation. The bench holds `src_valid` low past a small maximum count, checks that the starve flag is set while ready stays low, and then completes the fill to show that collection continued.

// File: rtl/rwb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the random word buffer.
// Assumes a 32-bit register data path and byte-addressed 8-bit offsets.
package rwb_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int CYC_W      = 16;
    localparam int MIN_W      = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h18;

    localparam int ST_READY    = 0;
    localparam int ST_STARVE   = 1;
    localparam int CTRL_EN_BIT = 10;
    localparam int CFG_MAX_LSB = 16;
endpackage

// File: rtl/rwb_bit_collector.sv
`timescale 1ns/1ps
// Module: rwb_bit_collector
// Shifts accepted source bits into a buffer, earliest bit ending at the MSB,
// and counts them up to TOTAL_BITS. Assumes clear and run are never both high.
module rwb_bit_collector #(
    parameter int TOTAL_BITS = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  run,
    input  logic                  src_valid,
    input  logic                  src_bit,
    output logic [TOTAL_BITS-1:0] bits_q,
    output logic                  full
);
    localparam int CNT_W = $clog2(TOTAL_BITS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign full   = (cnt_q == CNT_W'(TOTAL_BITS));
    assign accept = run && src_valid && !full;

    // Track how many bits the current fill has taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (accept) cnt_q <= cnt_q + 1'b1;
    end

    // Shift each accepted bit in at the LSB end.
    always_ff @(posedge clk) begin
        if (!rst_n)      bits_q <= '0;
        else if (accept) bits_q <= {bits_q[TOTAL_BITS-2:0], src_bit};
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TOTAL_BITS));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(bits_q));
endmodule

// File: rtl/rwb_fill_timer.sv
`timescale 1ns/1ps
// Module: rwb_fill_timer
// Counts cycles spent in the current fill, saturating. Declares the fill done
// once the buffer is full and the minimum count is met. Flags starvation when
// the maximum count is reached before the buffer is full (a maximum of 0 disables this).
module rwb_fill_timer #(
    parameter int CYC_W = 16,
    parameter int MIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             full,
    input  logic [MIN_W-1:0] min_cyc,
    input  logic [CYC_W-1:0] max_cyc,
    output logic             done,
    output logic             starve,
    output logic [CYC_W-1:0] cyc_q
);
    // Count fill cycles, restarting on clear and holding at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cyc_q <= '0;
        else if (clear)                 cyc_q <= '0;
        else if (run && (cyc_q != '1))  cyc_q <= cyc_q + 1'b1;
    end

    // Completion and starvation decisions for this cycle.
    always_comb begin
        done   = run && full && (cyc_q >= CYC_W'(min_cyc));
        starve = run && !full && (max_cyc != '0) && (cyc_q == max_cyc);
    end
endmodule

// File: rtl/rwb_csr.sv
`timescale 1ns/1ps
// Module: rwb_csr
// Register file: the output words (read only), the status flags (write one to
// clear), the control register (enable and interrupt masks) and the pacing
// configuration. Reads are combinational and free of side effects.
module rwb_csr
    import rwb_pkg::*;
#(
    parameter int NUM_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic [NUM_WORDS*DATA_W-1:0] buffer_bits,
    input  logic                        fill_done,
    input  logic                        starve_hit,
    output logic                        enable,
    output logic [MIN_W-1:0]            min_cyc,
    output logic [CYC_W-1:0]            max_cyc,
    output logic                        ready,
    output logic                        clear_fill,
    output logic                        irq
);
    localparam int TOTAL_BITS = NUM_WORDS * DATA_W;

    logic       status_wr, ctrl_wr, cfg_wr;
    logic       ready_q, starve_q, en_q;
    logic [1:0] mask_q;
    logic       unused_wr_bits;

    assign status_wr      = wr_en && (wr_addr == OFS_STATUS);
    assign ctrl_wr        = wr_en && (wr_addr == OFS_CTRL);
    assign cfg_wr         = wr_en && (wr_addr == OFS_CFG);
    assign unused_wr_bits = ^{wr_data[15:11], wr_data[9:8]};

    // Status flags: ready is set by the engine and starve by the timer; software clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b0;
            starve_q <= 1'b0;
        end else begin
            if (status_wr && wr_data[ST_READY]) ready_q <= 1'b0;
            else if (fill_done)                 ready_q <= 1'b1;
            if (starve_hit)                          starve_q <= 1'b1;
            else if (status_wr && wr_data[ST_STARVE]) starve_q <= 1'b0;
        end
    end

    // Control register: engine enable and the two interrupt masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= '0;
        end else if (ctrl_wr) begin
            en_q   <= wr_data[CTRL_EN_BIT];
            mask_q <= wr_data[1:0];
        end
    end

    // Pacing configuration: maximum and minimum refill cycle counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_cyc <= '0;
            min_cyc <= '0;
        end else if (cfg_wr) begin
            max_cyc <= wr_data[CFG_MAX_LSB +: CYC_W];
            min_cyc <= wr_data[MIN_W-1:0];
        end
    end

    // Read multiplexer over the output words and the three registers.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (rd_addr == ADDR_W'(4 * k))
                rd_data = buffer_bits[TOTAL_BITS-1-DATA_W*k -: DATA_W];
        end
        if (rd_addr == OFS_STATUS) begin
            rd_data[ST_READY]  = ready_q;
            rd_data[ST_STARVE] = starve_q;
        end
        if (rd_addr == OFS_CTRL) begin
            rd_data[CTRL_EN_BIT] = en_q;
            rd_data[1:0]         = mask_q;
        end
        if (rd_addr == OFS_CFG) begin
            rd_data[CFG_MAX_LSB +: CYC_W] = max_cyc;
            rd_data[MIN_W-1:0]            = min_cyc;
        end
    end

    assign enable     = en_q;
    assign ready      = ready_q;
    assign clear_fill = !en_q || (status_wr && wr_data[ST_READY] && ready_q);
    assign irq        = (ready_q && mask_q[0]) || (starve_q && mask_q[1]);

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q && !(status_wr && wr_data[ST_READY]) |=> ready_q);

    assert_starve_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        starve_q && !(status_wr && wr_data[ST_STARVE]) |=> starve_q);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready_q || starve_q));
endmodule

// File: rtl/rng_word_buffer.sv
`timescale 1ns/1ps
// Module: rng_word_buffer (top)
// Collects NUM_WORDS*32 random bits per fill and exposes them as read-only
// words with a write-one-to-clear ready handshake. Fills are paced by
// configurable minimum and maximum cycle counts.
module rng_word_buffer
    import rwb_pkg::*;
#(
    parameter int NUM_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic              src_bit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int TOTAL_BITS = NUM_WORDS * DATA_W;

    logic [TOTAL_BITS-1:0] buffer_bits;
    logic                  full, run, clear_fill, enable, ready;
    logic                  fill_done, starve_hit;
    logic [MIN_W-1:0]      min_cyc;
    logic [CYC_W-1:0]      max_cyc, cyc_q;

    assign run = enable && !ready;

    rwb_bit_collector #(.TOTAL_BITS(TOTAL_BITS)) u_collect (
        .clk(clk), .rst_n(rst_n), .clear(clear_fill), .run(run),
        .src_valid(src_valid), .src_bit(src_bit),
        .bits_q(buffer_bits), .full(full)
    );

    rwb_fill_timer #(.CYC_W(CYC_W), .MIN_W(MIN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(clear_fill), .run(run), .full(full),
        .min_cyc(min_cyc), .max_cyc(max_cyc),
        .done(fill_done), .starve(starve_hit), .cyc_q(cyc_q)
    );

    rwb_csr #(.NUM_WORDS(NUM_WORDS)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .buffer_bits(buffer_bits), .fill_done(fill_done),
        .starve_hit(starve_hit), .enable(enable), .min_cyc(min_cyc),
        .max_cyc(max_cyc), .ready(ready), .clear_fill(clear_fill), .irq(irq)
    );

    assert_full_before_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(full));

    assert_min_pace_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cyc_q) >= CYC_W'($past(min_cyc))));

    assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !$rose(ready));
endmodule

// File: tb/rng_word_buffer_test.sv
`timescale 1ns/1ps
// Bench for rng_word_buffer: a vector table walked by one loop, then directed cases.
module rng_word_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_valid = 1'b0, src_bit = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [31:0] EN = 32'h0000_0400;
    localparam logic [127:0] VECS [4] = '{
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'hFFFF_FFFF_0000_0000_A5A5_A5A5_5A5A_5A5A,
        128'h8000_0001_7FFF_FFFE_DEAD_BEEF_C0FF_EE00,
        128'h1357_9BDF_2468_ACE0_0F0F_F0F0_3C3C_C3C3
    };
    localparam logic [127:0] PAT_B = 128'hCAFE_F00D_1234_8765_0BAD_F00D_9999_6666;
    localparam logic [127:0] PAT_C = 128'h7777_1111_EEEE_2222_0101_1010_ABAB_CDCD;

    always #4 clk = ~clk;

    rng_word_buffer uut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_bit(src_bit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic feed(input logic [127:0] v, input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            src_valid = 1'b1;
            src_bit   = v[127-i];
            @(negedge clk);
        end
        src_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_words(input string req, input logic [127:0] v);
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            rd(8'(4 * k), d);
            check(req, d, v[127-32*k -: 32]);
        end
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] w0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h10, d); check("R1 status", d, 32'h0);
        rd(8'h14, d); check("R1 control", d, 32'h0);
        rd(8'h18, d); check("R1 config", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R10: register readback masks
        wr(8'h18, 32'hABCD_12EF);
        rd(8'h18, d); check("R10 config", d, 32'hABCD_00EF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R10 control", d, 32'h0000_0403);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'h0);

        // Table walk: R2, R3, R6, R7, R9
        wr(8'h14, EN | 32'h1);
        for (int v = 0; v < 4; v++) begin
            feed(VECS[v], 0, 128);
            idle(3);
            rd(8'h10, d); check("R3 ready after 128 bits", d, 32'h1);
            check("R9 irq on ready", {31'b0, irq}, 32'h1);
            check_words("R2 word order", VECS[v]);
            if (v == 0) begin
                rd(8'h00, w0);
                feed(~VECS[v], 0, 40);
                idle(2);
                rd(8'h00, d); check("R6 word frozen", d, w0);
                check_words("R6 all words frozen", VECS[v]);
            end
            if (v == 3) begin
                wr(8'h10, 32'h0);
                rd(8'h10, d); check("R7 write zero keeps ready", d, 32'h1);
                rd(8'h10, d); check("R7 read has no effect", d, 32'h1);
            end
            wr(8'h10, 32'h1);
            rd(8'h10, d); check("R7 ack clears ready", d, 32'h0);
            check("R9 irq low after ack", {31'b0, irq}, 32'h0);
        end

        // R3: 127 bits do not complete a fill
        feed(PAT_C, 0, 127);
        idle(5);
        rd(8'h10, d); check("R3 127 bits not ready", d, 32'h0);
        feed(PAT_C, 127, 1);
        idle(3);
        rd(8'h10, d); check("R3 128th bit completes", d, 32'h1);
        check_words("R2 words after split feed", PAT_C);
        wr(8'h10, 32'h1);

        // R5: disable abandons a partial fill
        feed(PAT_C, 0, 64);
        wr(8'h14, 32'h0);
        feed(PAT_B, 0, 20);
        idle(3);
        rd(8'h10, d); check("R5 no ready while disabled", d, 32'h0);
        wr(8'h14, EN | 32'h1);
        feed(PAT_B, 0, 128);
        idle(3);
        rd(8'h10, d); check("R5 ready after restart", d, 32'h1);
        check_words("R5 fresh fill only", PAT_B);

        // R4: minimum pacing of 200 cycles
        wr(8'h18, 32'h0000_00C8);
        wr(8'h10, 32'h1);
        feed(VECS[1], 0, 128);
        idle(62);
        rd(8'h10, d); check("R4 held by minimum", d, 32'h0);
        idle(15);
        rd(8'h10, d); check("R4 ready after minimum", d, 32'h1);
        check_words("R4 words", VECS[1]);

        // R8: starvation at maximum of 50 cycles
        wr(8'h18, 32'h0032_0000);
        wr(8'h10, 32'h1);
        idle(60);
        rd(8'h10, d); check("R8 starve set", d, 32'h2);
        check("R9 irq masked off", {31'b0, irq}, 32'h0);
        wr(8'h14, EN | 32'h3);
        check("R9 irq on starve", {31'b0, irq}, 32'h1);
        feed(VECS[2], 0, 128);
        idle(3);
        rd(8'h10, d); check("R8 fill continues", d, 32'h3);
        check_words("R8 words", VECS[2]);
        wr(8'h10, 32'h2);
        rd(8'h10, d); check("R8 starve cleared, ready kept", d, 32'h1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule